// File: doc/BRIEF.md
# Resistive touch measurement sequencer

This block paces the measurement of a four-wire resistive touch panel. A slow tick, typically about 32 kHz, sets the pace. While the automatic-capture bit of its control word is set, the block cycles through a fixed chain of phases. First comes a settle wait, then an X conversion, then the same settle wait again, then a Y conversion. Three more waits follow: a detect wait, a touch wait and a rest wait. After the rest wait the chain starts over. Each wait counts a programmable number of ticks. Each conversion phase opens with a one-cycle request strobe for its axis and then waits for the converter's done handshake.

Once both axes of a pass have been converted, the block emits one packed sample word for a downstream FIFO. The word carries the pen level and both codes. Each code is cut down to the resolution selected per axis in the control word. The control word and the four delays are loaded through a plain write port. A power-up bit in the control word is driven straight out to the converter. The analog switching and the converter itself live outside the block.

Top module: `touch_seq`

## Requirements
- R1: A pass issues `start_x`, then `start_y`, then pushes one sample; the two strobes are never high together, and a `start_y` always follows a `start_x`.
- R2: The settle phase between the axes lasts the settle delay (register address 1). With `tick` held high, `start_y` rises exactly settle+2 cycles after the cycle in which X's `adc_done` is accepted.
- R3: After Y's done, the chain runs through the detect (address 2), touch (address 3), rest (address 4) and settle phases in that order. With `tick` held high, the next `start_x` rises detect+touch+rest+settle+5 cycles after the Y done cycle.
- R4: Delay phases count only clocks on which `tick` is high. With `tick` low, a phase loaded with a nonzero value never ends.
- R5: Each conversion phase raises its strobe for exactly its first cycle. It then stays until `adc_done` is high, which may already happen in the strobe cycle.
- R6: `smp_valid` pulses for one cycle, one cycle after Y's done. `smp_word` holds the pen level in bit 31 (1 = pen up, sampled with Y's done), the X code in bits 25:16 and the Y code in bits 9:0. All other bits are zero.
- R7: Control bits 9:7 (X) and 6:4 (Y) give 10 minus the wanted resolution. A field value F clears the low F bits of that axis's code; 0 keeps all 10 bits.
- R8: Control bit 0 enables automatic capture. Setting it from idle starts at the settle phase before X. Clearing it lets the current phase finish and then returns to idle: no further strobes or samples follow.
- R9: Control bit 2 drives `conv_pwr`. Writes to control address 0 update it on the next cycle.
- R10: A delay write takes effect when a phase that uses it is next entered; a count already under way keeps its loaded value.
- R11: Synchronous active-low reset gives idle, auto off, power off, all delays zero and all outputs low. With zero delays and `tick` high, the strobe gaps are 4 (X to Y) and 7 (Y to X) when done comes two cycles after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow-time enable for delay counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 settle, 2 detect, 3 touch, 4 rest |
| wr_data | input | DATA_W (16) | Write data; delays use the low DLY_W bits |
| adc_done | input | 1 | Converter done handshake |
| adc_code | input | 10 | Converter result |
| pen_up | input | 1 | Pen level, 1 = no touch |
| conv_pwr | output | 1 | Converter power-up level |
| start_x | output | 1 | X conversion request strobe |
| start_y | output | 1 | Y conversion request strobe |
| smp_valid | output | 1 | Sample word valid pulse |
| smp_word | output | 32 | Packed sample word |

## Verification
The bench builds the block with its default parameters: 8-bit delay counters and a 16-bit write port. With these, delays from 0 to 255 ticks are reachable. The bench uses 0 up to 88 so that whole measurement passes, including the all-zero delays left by reset, complete in well under a thousand cycles. Holding `tick` high turns every phase length into an exact cycle count, so every strobe gap can be predicted. Holding `tick` low makes the stall of a delay phase visible at the strobe outputs.

// File: rtl/touch_seq_pkg.sv
// Shared constants, phase encoding and code-trimming helper for the
// resistive touch measurement sequencer.
package touch_seq_pkg;

    localparam int CODE_W = 10;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_SETTLE = 3'd1;
    localparam logic [ADDR_W-1:0] A_DETECT = 3'd2;
    localparam logic [ADDR_W-1:0] A_TOUCH  = 3'd3;
    localparam logic [ADDR_W-1:0] A_REST   = 3'd4;

    typedef enum logic [2:0] {
        PH_OFF, PH_SET_X, PH_CONV_X, PH_SET_Y,
        PH_CONV_Y, PH_DETECT, PH_TOUCH, PH_REST
    } phase_e;

    // Clear the low 'drop' bits of a converter code.
    function automatic logic [CODE_W-1:0] trim_code(input logic [CODE_W-1:0] code,
                                                    input logic [2:0] drop);
        logic [CODE_W-1:0] keep;
        keep = {CODE_W{1'b1}} << drop;
        return code & keep;
    endfunction

endpackage

// File: rtl/touch_seq_regs.sv
// Register file: control word plus four delay values.
// Assumes DATA_W > 10 and DLY_W <= DATA_W.
module touch_seq_regs
    import touch_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              auto_en,
    output logic              pwr_up,
    output logic [2:0]        x_drop,
    output logic [2:0]        y_drop,
    output logic [DLY_W-1:0]  dly_settle,
    output logic [DLY_W-1:0]  dly_detect,
    output logic [DLY_W-1:0]  dly_touch,
    output logic [DLY_W-1:0]  dly_rest
);

    logic wr_unused;
    assign wr_unused = ^{wr_data[DATA_W-1:10], wr_data[3], wr_data[1]};

    // Capture writes into the addressed register; reset clears all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_en    <= 1'b0;
            pwr_up     <= 1'b0;
            x_drop     <= '0;
            y_drop     <= '0;
            dly_settle <= '0;
            dly_detect <= '0;
            dly_touch  <= '0;
            dly_rest   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    auto_en <= wr_data[0];
                    pwr_up  <= wr_data[2];
                    y_drop  <= wr_data[6:4];
                    x_drop  <= wr_data[9:7];
                end
                A_SETTLE: dly_settle <= wr_data[DLY_W-1:0];
                A_DETECT: dly_detect <= wr_data[DLY_W-1:0];
                A_TOUCH:  dly_touch  <= wr_data[DLY_W-1:0];
                A_REST:   dly_rest   <= wr_data[DLY_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/touch_seq_ctrl.sv
// Phase controller: walks the measurement chain, counts delay phases in
// ticks, issues conversion strobes and flags accepted done handshakes.
// Assumes delay values are read only on entry to a phase.
module touch_seq_ctrl
    import touch_seq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             auto_en,
    input  logic [DLY_W-1:0] dly_settle,
    input  logic [DLY_W-1:0] dly_detect,
    input  logic [DLY_W-1:0] dly_touch,
    input  logic [DLY_W-1:0] dly_rest,
    input  logic             adc_done,
    output logic             start_x,
    output logic             start_y,
    output logic             x_take,
    output logic             y_take
);

    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    phase_e           ph, ph_n;
    logic [DLY_W-1:0] cnt, load_val;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign x_take   = (ph == PH_CONV_X) && adc_done;
    assign y_take   = (ph == PH_CONV_Y) && adc_done;

    // Next phase: each phase ends on count expiry or done, then idles if auto is off.
    always_comb begin
        ph_n = ph;
        case (ph)
            PH_OFF:    if (auto_en)  ph_n = PH_SET_X;
            PH_SET_X:  if (cnt_zero) ph_n = auto_en ? PH_CONV_X : PH_OFF;
            PH_CONV_X: if (adc_done) ph_n = auto_en ? PH_SET_Y  : PH_OFF;
            PH_SET_Y:  if (cnt_zero) ph_n = auto_en ? PH_CONV_Y : PH_OFF;
            PH_CONV_Y: if (adc_done) ph_n = auto_en ? PH_DETECT : PH_OFF;
            PH_DETECT: if (cnt_zero) ph_n = auto_en ? PH_TOUCH  : PH_OFF;
            PH_TOUCH:  if (cnt_zero) ph_n = auto_en ? PH_REST   : PH_OFF;
            PH_REST:   if (cnt_zero) ph_n = auto_en ? PH_SET_X  : PH_OFF;
            default:   ph_n = PH_OFF;
        endcase
    end

    // Delay value for the phase about to be entered.
    always_comb begin
        case (ph_n)
            PH_SET_X, PH_SET_Y: load_val = dly_settle;
            PH_DETECT:          load_val = dly_detect;
            PH_TOUCH:           load_val = dly_touch;
            PH_REST:            load_val = dly_rest;
            default:            load_val = '0;
        endcase
    end

    // Advance phase, load or decrement the counter, and form entry strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_OFF;
            cnt     <= '0;
            start_x <= 1'b0;
            start_y <= 1'b0;
        end else begin
            ph <= ph_n;
            if (ph_n != ph)
                cnt <= load_val;
            else if (tick && !cnt_zero)
                cnt <= cnt - DLY_ONE;
            start_x <= (ph_n == PH_CONV_X) && (ph != PH_CONV_X);
            start_y <= (ph_n == PH_CONV_Y) && (ph != PH_CONV_Y);
        end
    end

endmodule

// File: rtl/touch_seq_pack.sv
// Sample assembler: trims each axis code to its resolution, holds X, and
// registers the packed word with a valid pulse when Y completes.
module touch_seq_pack
    import touch_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_take,
    input  logic              y_take,
    input  logic [CODE_W-1:0] adc_code,
    input  logic              pen_up,
    input  logic [2:0]        x_drop,
    input  logic [2:0]        y_drop,
    output logic              smp_valid,
    output logic [31:0]       smp_word
);

    localparam int N_AXES = 2;

    logic [N_AXES-1:0][2:0]        drops;
    logic [N_AXES-1:0][CODE_W-1:0] trimmed;
    logic [CODE_W-1:0]             x_hold;

    assign drops = {y_drop, x_drop};

    // One trimming path per axis.
    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        assign trimmed[a] = trim_code(adc_code, drops[a]);
    end

    // Hold X, then emit the word one cycle after Y is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_hold    <= '0;
            smp_valid <= 1'b0;
            smp_word  <= '0;
        end else begin
            smp_valid <= y_take;
            if (x_take)
                x_hold <= trimmed[0];
            if (y_take)
                smp_word <= {pen_up, 5'b0, x_hold, 6'b0, trimmed[1]};
        end
    end

endmodule

// File: rtl/touch_seq.sv
// Top of the resistive touch measurement sequencer: register file, phase
// controller and sample assembler. Assumes one converter shared by both axes.
module touch_seq
    import touch_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              adc_done,
    input  logic [9:0]        adc_code,
    input  logic              pen_up,
    output logic              conv_pwr,
    output logic              start_x,
    output logic              start_y,
    output logic              smp_valid,
    output logic [31:0]       smp_word
);

    logic             auto_en, x_take, y_take;
    logic [2:0]       x_drop, y_drop;
    logic [DLY_W-1:0] dly_settle, dly_detect, dly_touch, dly_rest;

    touch_seq_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .auto_en(auto_en), .pwr_up(conv_pwr),
        .x_drop(x_drop), .y_drop(y_drop), .dly_settle(dly_settle),
        .dly_detect(dly_detect), .dly_touch(dly_touch), .dly_rest(dly_rest)
    );

    touch_seq_ctrl #(.DLY_W(DLY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .auto_en(auto_en),
        .dly_settle(dly_settle), .dly_detect(dly_detect),
        .dly_touch(dly_touch), .dly_rest(dly_rest), .adc_done(adc_done),
        .start_x(start_x), .start_y(start_y), .x_take(x_take), .y_take(y_take)
    );

    touch_seq_pack u_pack (
        .clk(clk), .rst_n(rst_n), .x_take(x_take), .y_take(y_take),
        .adc_code(adc_code), .pen_up(pen_up), .x_drop(x_drop),
        .y_drop(y_drop), .smp_valid(smp_valid), .smp_word(smp_word)
    );

endmodule

// File: rtl/touch_seq_chk.sv
// Property checker for touch_seq, attached by bind. Observes ports only.
module touch_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic        pwr_bit,
    input logic        adc_done,
    input logic        conv_pwr,
    input logic        start_x,
    input logic        start_y,
    input logic        smp_valid,
    input logic [10:0] word_gaps
);

    logic rst_q, seen, x_last;

    // Track reset history and whether an X strobe awaits its Y strobe.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        seen  <= 1'b1;
        if (!rst_n)       x_last <= 1'b0;
        else if (start_x) x_last <= 1'b1;
        else if (start_y) x_last <= 1'b0;
    end

    // R11: outputs quiet right after a reset cycle.
    always @(posedge clk) begin
        if (seen && !rst_q)
            p_reset_quiet_r11: assert (!start_x && !start_y && !smp_valid && !conv_pwr);
    end

    p_no_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_x && start_y));

    p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_y |-> x_last);

    p_single_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_x |=> !start_x);

    p_single_y_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_y |=> !start_y);

    p_push_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(adc_done));

    p_word_gaps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (word_gaps == '0));

    p_pwr_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_wr) && $past(rst_n)) |-> (conv_pwr == $past(pwr_bit)));

    p_pwr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_wr) && $past(rst_n)) |-> $stable(conv_pwr));

endmodule

bind touch_seq touch_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_en && (wr_addr == 3'd0)), .pwr_bit(wr_data[2]),
    .adc_done(adc_done), .conv_pwr(conv_pwr), .start_x(start_x),
    .start_y(start_y), .smp_valid(smp_valid),
    .word_gaps({smp_word[30:26], smp_word[15:10]})
);

// File: tb/tb_touch_seq.sv
`timescale 1ns/1ps
module tb_touch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        adc_done = 1'b0;
    logic [9:0]  adc_code = '0;
    logic        pen_up = 1'b0;
    logic        conv_pwr, start_x, start_y, smp_valid;
    logic [31:0] smp_word;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    // ADC model state: done comes two cycles after a strobe.
    int          pend = 0;
    logic        which_y = 1'b0;
    logic [9:0]  cx = '0, cy = '0;

    typedef struct packed {
        logic [7:0] s, d, t, u;
        logic [2:0] xd, yd;
        logic [9:0] xc, yc;
        logic       pen;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd2, 8'd4, 8'd16, 8'd88, 3'd0, 3'd0, 10'h3A5, 10'h15A, 1'b0},
        '{8'd0, 8'd0, 8'd0,  8'd0,  3'd3, 3'd7, 10'h3FF, 10'h3FF, 1'b1},
        '{8'd7, 8'd1, 8'd3,  8'd5,  3'd1, 3'd2, 10'h2AB, 10'h0D7, 1'b0},
        '{8'd1, 8'd9, 8'd2,  8'd0,  3'd5, 3'd0, 10'h155, 10'h000, 1'b1}
    };

    touch_seq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .adc_done(adc_done),
        .adc_code(adc_code), .pen_up(pen_up), .conv_pwr(conv_pwr),
        .start_x(start_x), .start_y(start_y), .smp_valid(smp_valid),
        .smp_word(smp_word)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        adc_done = 1'b0;
        if (!rst_n) pend = 0;
        else if (pend == 1) begin
            adc_done = 1'b1;
            adc_code = which_y ? cy : cx;
            pend = 0;
        end else if (pend > 1) pend = pend - 1;
        if (start_x) begin pend = 2; which_y = 1'b0; end
        if (start_y) begin pend = 2; which_y = 1'b1; end
    end

    function automatic logic [9:0] keep_top(input logic [9:0] c, input int drop);
        return (c >> drop) << drop;
    endfunction

    function automatic logic [15:0] ctl(input logic [2:0] xd, input logic [2:0] yd,
                                        input logic pwr, input logic auto_on);
        return {6'b0, xd, yd, 1'b0, pwr, 1'b0, auto_on};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // which: 0 start_x, 1 start_y, 2 smp_valid
    task automatic wait_hi(input int which, input int limit, output int t);
        t = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if ((which == 0 && start_x) || (which == 1 && start_y) ||
                (which == 2 && smp_valid)) begin
                t = cyc;
                return;
            end
        end
    endtask

    // which: 0 start_x, 1 start_y, 3 either strobe
    task automatic count_hi(input int which, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((which == 0 && start_x) || (which == 1 && start_y) ||
                (which == 3 && (start_x || start_y))) c++;
        end
    endtask

    task automatic stop_run();
        wreg(3'd0, 16'h0);
        repeat (300) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3, c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick  = 1'b1;
        @(negedge clk);

        // R11: reset state at the outputs
        check("R11 start_x after reset", start_x, 0);
        check("R11 start_y after reset", start_y, 0);
        check("R11 smp_valid after reset", smp_valid, 0);
        check("R11 conv_pwr after reset", conv_pwr, 0);
        check("R11 smp_word after reset", smp_word, 0);

        // R11: delays zero after reset, only auto is written
        wreg(3'd0, ctl(0, 0, 0, 1));
        wait_hi(0, 500, t0);
        wait_hi(1, 500, t1);
        wait_hi(0, 500, t2);
        check("R11 zero-delay x->y gap", t1 - t0, 4);
        check("R11 zero-delay y->x gap", t2 - t1, 7);
        stop_run();

        // R9: power bit
        wreg(3'd0, ctl(0, 0, 1, 0));
        @(negedge clk);
        check("R9 conv_pwr set", conv_pwr, 1);
        wreg(3'd0, ctl(0, 0, 0, 0));
        @(negedge clk);
        check("R9 conv_pwr cleared", conv_pwr, 0);

        // Vector table: R1 R2 R3 R5 R6 R7 R8
        foreach (VECS[k]) begin
            vec_t v;
            logic [31:0] exp_w;
            v = VECS[k];
            wreg(3'd1, {8'h0, v.s});
            wreg(3'd2, {8'h0, v.d});
            wreg(3'd3, {8'h0, v.t});
            wreg(3'd4, {8'h0, v.u});
            cx = v.xc; cy = v.yc; pen_up = v.pen;
            wreg(3'd0, ctl(v.xd, v.yd, 0, 1));
            wait_hi(0, 500, t0);
            wait_hi(1, 500, t1);
            check("R2 settle gap x->y", t1 - t0, 32'(v.s) + 4);
            wait_hi(2, 500, t2);
            check("R5 R6 valid after y strobe", t2 - t1, 3);
            exp_w = {v.pen, 5'b0, keep_top(v.xc, int'(v.xd)), 6'b0, keep_top(v.yc, int'(v.yd))};
            check("R1 R6 R7 sample word", smp_word, exp_w);
            wait_hi(0, 500, t3);
            check("R3 chain gap y->x", t3 - t1,
                  32'(v.d) + 32'(v.t) + 32'(v.u) + 32'(v.s) + 7);
            wreg(3'd0, ctl(v.xd, v.yd, 0, 0));
            count_hi(1, 200, c);
            check("R8 no y strobe after auto cleared in conversion", c, 0);
            repeat (100) @(negedge clk);
        end

        // R4: tick low stalls a nonzero delay phase
        tick = 1'b0;
        wreg(3'd1, 16'd3);
        wreg(3'd2, 16'd0);
        wreg(3'd3, 16'd0);
        wreg(3'd4, 16'd0);
        wreg(3'd0, ctl(0, 0, 0, 1));
        count_hi(0, 100, c);
        check("R4 no start_x while tick low", c, 0);
        tick = 1'b1;
        wait_hi(0, 50, t0);
        check("R4 start_x once ticks resume", (t0 >= 0), 1);
        stop_run();

        // R10: delay write during a count applies on next entry
        wreg(3'd1, 16'd20);
        wreg(3'd0, ctl(0, 0, 0, 1));
        wait_hi(0, 500, t0);
        repeat (6) @(negedge clk);
        wreg(3'd1, 16'd3);
        wait_hi(1, 500, t1);
        check("R10 running count keeps old value", t1 - t0, 24);
        wait_hi(0, 500, t2);
        check("R10 next settle uses new value", t2 - t1, 10);
        wait_hi(1, 500, t3);
        check("R10 next x->y gap uses new value", t3 - t2, 7);
        stop_run();

        // R8: auto cleared during a delay phase ends the run
        wreg(3'd1, 16'd30);
        wreg(3'd0, ctl(0, 0, 0, 1));
        wait_hi(0, 500, t0);
        repeat (8) @(negedge clk);
        wreg(3'd0, ctl(0, 0, 0, 0));
        count_hi(3, 200, c);
        check("R8 no strobe after auto cleared in settle", c, 0);

        // R11: reset in mid-run clears delays and power
        wreg(3'd1, 16'd9);
        wreg(3'd2, 16'd5);
        wreg(3'd0, ctl(0, 0, 1, 1));
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 conv_pwr cleared by reset", conv_pwr, 0);
        wreg(3'd0, ctl(0, 0, 0, 1));
        wait_hi(0, 500, t0);
        wait_hi(1, 500, t1);
        wait_hi(0, 500, t2);
        check("R11 delays zero after mid-run reset x->y", t1 - t0, 4);
        check("R11 delays zero after mid-run reset y->x", t2 - t1, 7);
        stop_run();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule